// File: doc/BRIEF.md
# Soft-Start and Delayed Overcurrent Hiccup Supervisor

This block governs how a double-ended PWM core is brought up and how it reacts to overcurrent. It keeps a digital soft-start level, a saturating up/down counter whose value the PWM core uses as its duty-cycle ceiling. At power-up and after every fault the level climbs from the bottom, which widens the allowed pulse gradually. Once the level passes the completion code, the supervisor arms delayed overcurrent handling. An overcurrent flag does not stop switching at once. Charging stops, the level bleeds down slowly, and a retriggerable one-shot timer measures how long the overcurrent persists. The outputs are turned off only if the level drains to the trip code while that timer is still running.

After a shutdown the level keeps draining, with the outputs held off, until it reaches the reset code. A fresh soft-start then begins. This gives hiccup-mode retry for a persistent short. Undervoltage and over-temperature flags come from hysteretic comparators outside the block. Either flag forces the same shutdown immediately and holds it for as long as it is asserted. All analog thresholds become counter codes: 400 is the clamp, 350 the completion code, 390 the trip code and 27 the reset code. Every level change happens on a timebase tick.

The machine has four states. RESTART drains the level with the outputs disabled. RAMP charges the level. RUN holds the level at the clamp with overcurrent armed. OC_HOLD drains the level while the one-shot runs. The transitions are as follows:
- power-up: reset enters RESTART.
- restart exit: RESTART to RAMP.
- ramp done: RAMP to RUN.
- oc entry: RUN to OC_HOLD.
- oc recover: OC_HOLD to RUN.
- oc trip: OC_HOLD to RESTART.
- fault: any state to RESTART.

Top module: `ss_hiccup_supervisor`

## Requirements
- R1: While reset is asserted, and directly after it, `ss_level` is 0, `ss_done` is 0 and `out_disable` is 1 (state RESTART).
- R2: In RESTART, each tick with the level above the reset code (27) lowers the level by DRAIN_STEP (1), and the outputs stay disabled. On a tick where the level is at or below 27 and no fault flag is set, the machine moves to RAMP and leaves the level unchanged.
- R3: In RAMP, each tick raises the level by CHARGE_STEP (5), `out_disable` is 0, `ss_done` is 0, and `oc_flag` has no effect.
- R4: On the tick where the raised level first exceeds the completion code (350), the machine enters RUN and `ss_done` becomes 1. From reset, this is tick number floor(350/5)+2 = 72.
- R5: In RUN, a tick without `oc_flag` charges the level. A tick with `oc_flag` holds the level, loads the one-shot with OS_TICKS (6) and enters OC_HOLD. `ss_done` stays 1.
- R6: In OC_HOLD, each tick lowers the level by DRAIN_STEP. A tick with `oc_flag` reloads the one-shot to OS_TICKS, and a tick without it counts the one-shot down.
- R7: If a drain tick in OC_HOLD takes the level to or below the trip code (390), the machine enters RESTART and `out_disable` becomes 1 while the level reads the drained value. A sustained overcurrent from 400 therefore shuts down with the level at 390.
- R8: If the one-shot runs out (the tick that takes it from 1 to 0 with no `oc_flag`) before the trip, the machine returns to RUN and charging resumes. One overcurrent tick at level 400 recovers at level 394.
- R9: `uv_flag` or `ot_flag` forces RESTART in the next cycle from any state, with or without a tick. While either flag is held, the machine stays in RESTART.
- R10: Level changes happen only on `tick`. The level saturates at the clamp code 400 and never goes below 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase strobe; level and one-shot advance only on it |
| oc_flag | input | 1 | Per-cycle overcurrent indication, sampled on ticks |
| uv_flag | input | 1 | Supply undervoltage, already hysteretic |
| ot_flag | input | 1 | Over-temperature, already hysteretic |
| ss_level | output | LVL_W (12) | Soft-start level word for the PWM core |
| ss_done | output | 1 | Soft-start complete; overcurrent delay armed |
| out_disable | output | 1 | Forces both bridge outputs low |

## Verification
Every output comes from a register, so each result of a stimulus is due exactly one clock after the cycle in which that stimulus is held on the inputs. This applies to a tick, an overcurrent tick and a fault flag alike. The bench drives inputs on the falling edge and steps its reference model by one cycle per rising edge. It compares all three outputs on the following falling edge, so every expected value is tied to the one register stage in the path. Multi-tick results are counted in ticks from a known state rather than in absolute time: the 72-tick ramp, the 10-drain trip and the six-tick one-shot recovery.

// File: rtl/ss_hiccup_pkg.sv
package ss_hiccup_pkg;

    typedef enum logic [1:0] {
        SS_RESTART = 2'd0,
        SS_RAMP    = 2'd1,
        SS_RUN     = 2'd2,
        SS_OC_HOLD = 2'd3
    } ss_state_e;

    typedef enum logic [1:0] {
        LV_HOLD = 2'd0,
        LV_UP   = 2'd1,
        LV_DOWN = 2'd2
    } lvl_op_e;

endpackage

// File: rtl/ss_level_counter.sv
module ss_level_counter
    import ss_hiccup_pkg::*;
#(
    parameter int LVL_W       = 12,
    parameter int LVL_CLAMP   = 400,
    parameter int CHARGE_STEP = 5,
    parameter int DRAIN_STEP  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  lvl_op_e          op,
    output logic [LVL_W-1:0] lvl_q,
    output logic [LVL_W-1:0] lvl_nxt
);
    localparam logic [LVL_W-1:0] CLAMP_C  = LVL_W'(LVL_CLAMP);
    localparam logic [LVL_W-1:0] CHARGE_C = LVL_W'(CHARGE_STEP);
    localparam logic [LVL_W-1:0] DRAIN_C  = LVL_W'(DRAIN_STEP);

    always_comb begin
        lvl_nxt = lvl_q;
        if (tick) begin
            unique case (op)
                LV_UP:   lvl_nxt = (lvl_q >= CLAMP_C - CHARGE_C) ? CLAMP_C : lvl_q + CHARGE_C;
                LV_DOWN: lvl_nxt = (lvl_q <= DRAIN_C) ? '0 : lvl_q - DRAIN_C;
                default: lvl_nxt = lvl_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_nxt;
    end

    AST_LEVEL_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(lvl_q)); // R10
    AST_LEVEL_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_q <= CLAMP_C); // R10

endmodule

// File: rtl/ss_oneshot.sv
module ss_oneshot #(
    parameter int OS_TICKS = 6,
    localparam int OS_W    = $clog2(OS_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clear,
    input  logic trigger,
    output logic active,
    output logic last
);
    localparam logic [OS_W-1:0] LOAD_C = OS_W'(OS_TICKS);

    logic [OS_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (clear)                 cnt_q <= '0;
        else if (tick && trigger)       cnt_q <= LOAD_C;
        else if (tick && cnt_q != '0)   cnt_q <= cnt_q - OS_W'(1);
    end

    assign active = (cnt_q != '0);
    assign last   = (cnt_q == OS_W'(1));

    AST_ONESHOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD_C); // R6

endmodule

// File: rtl/ss_hiccup_supervisor.sv
module ss_hiccup_supervisor
    import ss_hiccup_pkg::*;
#(
    parameter int LVL_W       = 12,
    parameter int LVL_CLAMP   = 400,
    parameter int LVL_DONE    = 350,
    parameter int LVL_TRIP    = 390,
    parameter int LVL_RESET   = 27,
    parameter int CHARGE_STEP = 5,
    parameter int DRAIN_STEP  = 1,
    parameter int OS_TICKS    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             oc_flag,
    input  logic             uv_flag,
    input  logic             ot_flag,
    output logic [LVL_W-1:0] ss_level,
    output logic             ss_done,
    output logic             out_disable
);
    localparam logic [LVL_W-1:0] DONE_C  = LVL_W'(LVL_DONE);
    localparam logic [LVL_W-1:0] TRIP_C  = LVL_W'(LVL_TRIP);
    localparam logic [LVL_W-1:0] RESET_C = LVL_W'(LVL_RESET);

    ss_state_e        st_q, st_d;
    lvl_op_e          lvl_op;
    logic [LVL_W-1:0] lvl_q, lvl_nxt;
    logic             os_active, os_last, os_clear, fault;

    assign fault = uv_flag | ot_flag;

    ss_level_counter #(
        .LVL_W(LVL_W), .LVL_CLAMP(LVL_CLAMP),
        .CHARGE_STEP(CHARGE_STEP), .DRAIN_STEP(DRAIN_STEP)
    ) u_level (
        .clk(clk), .rst_n(rst_n), .tick(tick), .op(lvl_op),
        .lvl_q(lvl_q), .lvl_nxt(lvl_nxt)
    );

    assign os_clear = (st_q == SS_RESTART) || (st_q == SS_RAMP);

    ss_oneshot #(.OS_TICKS(OS_TICKS)) u_oneshot (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clear(os_clear),
        .trigger(oc_flag), .active(os_active), .last(os_last)
    );

    // level operation chosen by state
    always_comb begin
        unique case (st_q)
            SS_RESTART: lvl_op = (lvl_q > RESET_C) ? LV_DOWN : LV_HOLD;
            SS_RAMP:    lvl_op = LV_UP;
            SS_RUN:     lvl_op = oc_flag ? LV_HOLD : LV_UP;
            SS_OC_HOLD: lvl_op = LV_DOWN;
            default:    lvl_op = LV_HOLD;
        endcase
    end

    // next-state logic; fault is set-dominant over every transition
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SS_RESTART: if (tick && lvl_q <= RESET_C) st_d = SS_RAMP;
            SS_RAMP:    if (tick && lvl_nxt > DONE_C) st_d = SS_RUN;
            SS_RUN:     if (tick && oc_flag) st_d = SS_OC_HOLD;
            SS_OC_HOLD: begin
                if (tick) begin
                    if (lvl_nxt <= TRIP_C)        st_d = SS_RESTART;
                    else if (!oc_flag && os_last) st_d = SS_RUN;
                end
            end
            default:    st_d = SS_RESTART;
        endcase
        if (fault) st_d = SS_RESTART;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SS_RESTART;
        else        st_q <= st_d;
    end

    always_comb begin
        ss_level    = lvl_q;
        ss_done     = (st_q == SS_RUN) || (st_q == SS_OC_HOLD);
        out_disable = (st_q == SS_RESTART);
    end

    AST_FAULT_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> out_disable); // R9
    AST_DONE_ABOVE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_done) |-> ss_level > DONE_C); // R4
    AST_TRIP_AT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(out_disable) && !$past(fault)) |-> ss_level <= TRIP_C); // R7
    AST_RESTART_EXIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_disable) |-> ss_level <= RESET_C); // R2
    AST_DRAIN_TIMER_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SS_OC_HOLD) |-> os_active); // R6

endmodule

// File: tb/ss_hiccup_supervisor_tb.sv
module ss_hiccup_supervisor_tb;
    localparam int LVL_W = 12, CLAMP = 400, DONE = 350, TRIP = 390, RSTC = 27;
    localparam int CHG = 5, DRN = 1, OST = 6;
    localparam int ST_RESTART = 0, ST_RAMP = 1, ST_RUN = 2, ST_OC = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tick = 1'b0, oc_flag = 1'b0, uv_flag = 1'b0, ot_flag = 1'b0;
    logic [LVL_W-1:0] ss_level;
    logic ss_done, out_disable;

    int checks = 0, failures = 0;
    int m_st = ST_RESTART, m_lvl = 0, m_os = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ss_hiccup_supervisor #(
        .LVL_W(LVL_W), .LVL_CLAMP(CLAMP), .LVL_DONE(DONE), .LVL_TRIP(TRIP),
        .LVL_RESET(RSTC), .CHARGE_STEP(CHG), .DRAIN_STEP(DRN), .OS_TICKS(OST)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .oc_flag(oc_flag),
        .uv_flag(uv_flag), .ot_flag(ot_flag), .ss_level(ss_level),
        .ss_done(ss_done), .out_disable(out_disable)
    );

    function automatic int up(input int v);
        return (v + CHG > CLAMP) ? CLAMP : v + CHG;
    endfunction
    function automatic int dn(input int v);
        return (v <= DRN) ? 0 : v - DRN;
    endfunction
    function automatic string tag_of(input int st, input bit flt);
        if (flt) return "R9";
        case (st)
            ST_RESTART: return "R2";
            ST_RAMP:    return "R3";
            ST_RUN:     return "R5";
            default:    return "R6";
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one clock: drive at falling edge, model the edge, compare at next falling edge
    task automatic step(input bit t, input bit o, input bit u, input bit f);
        int nst, nlvl, nos;
        string req;
        tick = t; oc_flag = o; uv_flag = u; ot_flag = f;
        req = tag_of(m_st, u | f);
        nst = m_st; nlvl = m_lvl; nos = m_os;
        if (t) begin
            case (m_st)
                ST_RESTART: if (m_lvl > RSTC) nlvl = dn(m_lvl); else nst = ST_RAMP;
                ST_RAMP: begin nlvl = up(m_lvl); if (nlvl > DONE) nst = ST_RUN; end
                ST_RUN: if (o) nst = ST_OC; else nlvl = up(m_lvl);
                default: begin
                    nlvl = dn(m_lvl);
                    if (nlvl <= TRIP) nst = ST_RESTART;
                    else if (!o && m_os == 1) nst = ST_RUN;
                end
            endcase
        end
        if (m_st == ST_RESTART || m_st == ST_RAMP) nos = 0;
        else if (t && o) nos = OST;
        else if (t && m_os != 0) nos = m_os - 1;
        if (u || f) nst = ST_RESTART;
        @(posedge clk);
        @(negedge clk);
        m_st = nst; m_lvl = nlvl; m_os = nos;
        check(req, "ss_level", int'(ss_level), m_lvl);
        check(req, "ss_done", int'(ss_done), int'(m_st == ST_RUN || m_st == ST_OC));
        check(req, "out_disable", int'(out_disable), int'(m_st == ST_RESTART));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick = 0; oc_flag = 0; uv_flag = 0; ot_flag = 0;
        repeat (3) @(negedge clk);
        check("R1", "ss_level in reset", int'(ss_level), 0);
        check("R1", "ss_done in reset", int'(ss_done), 0);
        check("R1", "out_disable in reset", int'(out_disable), 1);
        rst_n = 1'b1;
        m_st = ST_RESTART; m_lvl = 0; m_os = 0;
        step(0, 0, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R4: ticks from reset to completion, with oc held high during the ramp (R3)
        n = 0;
        while (!ss_done && n < 200) begin step(1, 1, 0, 0); n++; end
        check("R4", "ticks to ss_done", n, DONE / CHG + 2);
        check("R4", "level at completion", int'(ss_level), (DONE / CHG + 1) * CHG);

        // R10: charge into the clamp
        repeat (20) step(1, 0, 0, 0);
        check("R10", "level saturates at clamp", int'(ss_level), CLAMP);
        repeat (5) step(0, 0, 0, 0);
        check("R10", "level stable without tick", int'(ss_level), CLAMP);

        // R8: single overcurrent tick, one-shot expires before trip
        step(1, 1, 0, 0);
        check("R5", "level held on oc entry", int'(ss_level), CLAMP);
        for (int i = 0; i < OST; i++) step(1, 0, 0, 0);
        check("R8", "recovered level", int'(ss_level), CLAMP - OST * DRN);
        check("R8", "outputs enabled after recovery", int'(out_disable), 0);
        step(1, 0, 0, 0);
        check("R8", "charging resumed", int'(ss_level), CLAMP - OST * DRN + CHG);
        repeat (5) step(1, 0, 0, 0);

        // R7: sustained overcurrent trips at the trip code
        n = 0;
        while (!out_disable && n < 100) begin step(1, 1, 0, 0); n++; end
        check("R7", "level at shutdown", int'(ss_level), TRIP);
        check("R7", "ticks to shutdown", n, 1 + (CLAMP - TRIP) / DRN);

        // R2: hiccup drain to the reset code, then restart
        n = 0;
        while (out_disable && n < 1000) begin step(1, 1, 0, 0); n++; end
        check("R2", "drain+exit ticks", n, (TRIP - RSTC) / DRN + 1);
        check("R2", "level at restart exit", int'(ss_level), RSTC);

        // R9: fault without tick during ramp, then held fault blocks restart
        step(0, 0, 1, 0);
        check("R9", "uv forces disable", int'(out_disable), 1);
        repeat (40) step(1, 0, 1, 0);
        check("R9", "held fault keeps disable", int'(out_disable), 1);
        step(1, 0, 0, 0);
        check("R9", "restart after fault clears", int'(out_disable), 0);
        repeat (80) step(1, 0, 0, 0);
        step(0, 0, 0, 1);
        check("R9", "ot forces disable from run", int'(out_disable), 1);

        // random phase
        for (int i = 0; i < 20000; i++) begin
            bit t, o, u, f;
            t = ($urandom % 2) == 0;
            o = ($urandom % 9) == 0;
            u = ($urandom % 400) == 0;
            f = ($urandom % 500) == 0;
            step(t, o, u, f);
            if (int'(ss_level) > CLAMP) check("R10", "random clamp", int'(ss_level), CLAMP);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule